// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in first-out buffer for 9-bit words. Its write port and its read port run on independent clocks. The depth is a power-of-two parameter: 64, 256, 512, 1024, 2048, 4096 or 8192 words. It reports full and empty. It also drives two active-low early-warning flags: one for nearly full and one for nearly empty. Each of these trips at a threshold given by a programmable offset.

The two offsets are programmed through the write data bus. A load select input, held high together with the primary write enable, routes the bus into a four-slot sequencer instead of into the storage. Each load edge fills one slot and then moves to the next slot, in a fixed cyclic order: nearly-empty low half, nearly-empty high half, nearly-full low half, nearly-full high half. The sequencer has four states, `LD_AE_LO`, `LD_AE_HI`, `LD_AF_LO` and `LD_AF_HI`. It steps from each state to the next on a load edge, wraps from `LD_AF_HI` back to `LD_AE_LO`, and holds its state when no load occurs. Reset returns the sequencer to `LD_AE_LO` and sets both offsets to DEPTH/8.

The nearly-full flag is registered in the write-clock domain. It sees reads only through a two-stage synchronizer on the Gray-coded read pointer, so it releases a few write-clock cycles after a read. The nearly-empty and empty flags live in the read-clock domain. One asynchronous active-low reset clears both domains.

Top module: `pflag_fifo`

## Requirements
- R1: While `rst_n` is low, and after its release until the first write, the outputs read `empty`=1, `full`=0, `almost_full_n`=1, `almost_empty_n`=0 and `rdata`=0. Reset returns the load sequencer to the nearly-empty low slot and sets both offsets to DEPTH/8.
- R2: A rising `wclk` edge stores `wdata` when `wen_a`=1, `wen_ld`=0 and `full`=0. A rising `rclk` edge with `ren_a`=1, `ren_b`=1 and `empty`=0 loads the oldest stored word into `rdata`. Words leave in the order they were written.
- R3: A write attempted while `full`=1, or a read attempted while `empty`=1, changes neither the pointers nor the stored words, and `rdata` holds its value.
- R4: Each rising `wclk` edge with `wen_a`=1 and `wen_ld`=1 stores `wdata` into the current offset slot and advances the slot. The slot order is nearly-empty low, nearly-empty high, nearly-full low, nearly-full high, then back to the first. A load edge never writes the storage.
- R5: Each offset is {high half, low half} of 18 bits, truncated to log2(DEPTH) bits. Bits above that width have no effect.
- R6: With nearly-full offset m, `almost_full_n` goes low when the write-side word count is at least DEPTH-m, and high when it is at most DEPTH-m-1.
- R7: `almost_full_n` is updated on each `wclk` edge from the count held before that edge's write. During a continuous write stream it therefore goes low on the edge that stores word DEPTH-m+1.
- R8: `almost_full_n` changes only on `wclk` edges. After a read, its release waits for the read pointer to pass through the two-stage synchronizer into the write domain.
- R9: With nearly-empty offset n, `almost_empty_n` is low when the read-side word count is at most n and high otherwise.
- R10: `full` is 1 exactly when DEPTH words are held, and `empty` is 1 exactly when none are held, once both pointer crossings have settled.
- R11: A read needs both `ren_a` and `ren_b`. `wen_ld` high without `wen_a` neither writes nor loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wen_a | input | 1 | Primary write enable |
| wen_ld | input | 1 | Load select: 1 sends bus words to the offset slots, 0 sends them to storage |
| wdata | input | 9 | Write data and offset load bus |
| ren_a | input | 1 | First read enable |
| ren_b | input | 1 | Second read enable |
| rdata | output | 9 | Word read out, registered on `rclk` |
| full | output | 1 | High when DEPTH words are held |
| empty | output | 1 | High when no words are held |
| almost_full_n | output | 1 | Low when the count is at or above DEPTH minus the nearly-full offset |
| almost_empty_n | output | 1 | Low when the count is at or below the nearly-empty offset |

## Verification
The bench places the count exactly on each side of both thresholds, for the default offsets, for programmed offsets and for offsets of zero. A design with an off-by-one comparison trips one word early or late. The bench streams writes and pins the exact edge where the nearly-full flag falls, which exposes a design that uses the count after the write instead of before it. It checks that the flag has not released right after a read edge, which catches a crossing that skips the synchronizer. It also overfills, over-reads, loads five words, resets mid-sequence and asserts a single enable. A design that corrupts a pointer returns words out of order, and a design that fails to wrap or reset the sequencer puts the offsets in the wrong slots.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;

    localparam int BUS_W = 9;

    typedef enum logic [1:0] {
        LD_AE_LO = 2'd0,
        LD_AE_HI = 2'd1,
        LD_AF_LO = 2'd2,
        LD_AF_HI = 2'd3
    } ld_state_e;

endpackage

// File: rtl/pflag_sync2.sv
module pflag_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/pflag_offset_loader.sv
module pflag_offset_loader
    import pflag_fifo_pkg::*;
#(
    parameter int OFF_W   = 6,
    parameter int RST_OFF = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_we,
    input  logic [BUS_W-1:0] din,
    output logic [OFF_W-1:0] ae_off,
    output logic [OFF_W-1:0] af_off,
    output ld_state_e        state
);

    localparam int EXT_W = 2 * BUS_W;
    localparam logic [EXT_W-1:0] RST_EXT = EXT_W'(RST_OFF);

    ld_state_e        state_nxt;
    logic [EXT_W-1:0] ae_ext, af_ext, ae_nxt, af_nxt;
    logic             unused_upper;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_AE_LO;
        else        state <= state_nxt;
    end

    // Next state and slot update
    always_comb begin
        state_nxt = state;
        ae_nxt    = ae_ext;
        af_nxt    = af_ext;
        if (ld_we) begin
            unique case (state)
                LD_AE_LO: begin
                    ae_nxt[BUS_W-1:0] = din;
                    state_nxt         = LD_AE_HI;
                end
                LD_AE_HI: begin
                    ae_nxt[EXT_W-1:BUS_W] = din;
                    state_nxt             = LD_AF_LO;
                end
                LD_AF_LO: begin
                    af_nxt[BUS_W-1:0] = din;
                    state_nxt         = LD_AF_HI;
                end
                LD_AF_HI: begin
                    af_nxt[EXT_W-1:BUS_W] = din;
                    state_nxt             = LD_AE_LO;
                end
                default: state_nxt = LD_AE_LO;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ae_ext <= RST_EXT;
            af_ext <= RST_EXT;
        end else begin
            ae_ext <= ae_nxt;
            af_ext <= af_nxt;
        end
    end

    assign ae_off       = ae_ext[OFF_W-1:0];
    assign af_off       = af_ext[OFF_W-1:0];
    assign unused_upper = ^{ae_ext[EXT_W-1:OFF_W], af_ext[EXT_W-1:OFF_W]};

endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo
    import pflag_fifo_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             wen_a,
    input  logic             wen_ld,
    input  logic [BUS_W-1:0] wdata,
    input  logic             ren_a,
    input  logic             ren_b,
    output logic [BUS_W-1:0] rdata,
    output logic             full,
    output logic             empty,
    output logic             almost_full_n,
    output logic             almost_empty_n
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PTR_W  = ADDR_W + 1;
    localparam int OFF_W  = ADDR_W;
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

    function automatic logic [PTR_W-1:0] to_gray(input logic [PTR_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PTR_W-1:0] from_gray(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [BUS_W-1:0] mem [DEPTH];

    logic [OFF_W-1:0] ae_off, af_off;
    ld_state_e        ld_state;

    // Write domain
    logic             wr_push, ld_we;
    logic [PTR_W-1:0] wbin, wgray, wbin_nxt, wgray_nxt, rgray_w, wcnt, af_thr;

    assign ld_we     = wen_a & wen_ld;
    assign wr_push   = wen_a & ~wen_ld & ~full;
    assign wbin_nxt  = wbin + PTR_W'(wr_push);
    assign wgray_nxt = to_gray(wbin_nxt);
    assign wcnt      = wbin - from_gray(rgray_w);
    assign af_thr    = DEPTH_P - {1'b0, af_off};

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wbin          <= '0;
            wgray         <= '0;
            full          <= 1'b0;
            almost_full_n <= 1'b1;
        end else begin
            wbin          <= wbin_nxt;
            wgray         <= wgray_nxt;
            full          <= (wgray_nxt == {~rgray_w[PTR_W-1:PTR_W-2], rgray_w[PTR_W-3:0]});
            almost_full_n <= (wcnt < af_thr);
        end
    end

    always_ff @(posedge wclk) begin
        if (wr_push) mem[wbin[ADDR_W-1:0]] <= wdata;
    end

    // Read domain
    logic             rd_pop;
    logic [PTR_W-1:0] rbin, rgray, rbin_nxt, rgray_nxt, wgray_r, rcnt;

    assign rd_pop    = ren_a & ren_b & ~empty;
    assign rbin_nxt  = rbin + PTR_W'(rd_pop);
    assign rgray_nxt = to_gray(rbin_nxt);
    assign rcnt      = from_gray(wgray_r) - rbin;

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rbin           <= '0;
            rgray          <= '0;
            empty          <= 1'b1;
            almost_empty_n <= 1'b0;
            rdata          <= '0;
        end else begin
            rbin           <= rbin_nxt;
            rgray          <= rgray_nxt;
            empty          <= (rgray_nxt == wgray_r);
            almost_empty_n <= (rcnt > {1'b0, ae_off});
            if (rd_pop) rdata <= mem[rbin[ADDR_W-1:0]];
        end
    end

    // Pointer crossings
    pflag_sync2 #(.W(PTR_W)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_w)
    );

    pflag_sync2 #(.W(PTR_W)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_r)
    );

    pflag_offset_loader #(.OFF_W(OFF_W), .RST_OFF(DEPTH / 8)) u_loader (
        .clk    (wclk),
        .rst_n  (rst_n),
        .ld_we  (ld_we),
        .din    (wdata),
        .ae_off (ae_off),
        .af_off (af_off),
        .state  (ld_state)
    );

endmodule

// File: rtl/pflag_fifo_chk.sv
module pflag_fifo_chk
    import pflag_fifo_pkg::*;
#(
    parameter int PTR_W = 7
) (
    input logic             wclk,
    input logic             rclk,
    input logic             rst_n,
    input logic             wen_a,
    input logic             wen_ld,
    input logic             ren_a,
    input logic             ren_b,
    input logic             full,
    input logic             empty,
    input logic [PTR_W-1:0] wbin,
    input logic [PTR_W-1:0] rbin,
    input ld_state_e        ld_state
);

    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
        (wen_a && !wen_ld && full) |=> (wbin == $past(wbin))); // R3

    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
        (ren_a && ren_b && empty) |=> (rbin == $past(rbin))); // R3

    AST_LOAD_NO_PUSH: assert property (@(posedge wclk) disable iff (!rst_n)
        (wen_a && wen_ld) |=> $stable(wbin)); // R4

    AST_LOAD_ADVANCE: assert property (@(posedge wclk) disable iff (!rst_n)
        (wen_a && wen_ld) |=> !$stable(ld_state)); // R4

    AST_IDLE_SLOT_HOLD: assert property (@(posedge wclk) disable iff (!rst_n)
        !(wen_a && wen_ld) |=> $stable(ld_state)); // R11

    AST_SINGLE_REN_NO_POP: assert property (@(posedge rclk) disable iff (!rst_n)
        (ren_a != ren_b) |=> $stable(rbin)); // R11

endmodule

bind pflag_fifo pflag_fifo_chk #(.PTR_W(PTR_W)) u_chk (
    .wclk     (wclk),
    .rclk     (rclk),
    .rst_n    (rst_n),
    .wen_a    (wen_a),
    .wen_ld   (wen_ld),
    .ren_a    (ren_a),
    .ren_b    (ren_b),
    .full     (full),
    .empty    (empty),
    .wbin     (wbin),
    .rbin     (rbin),
    .ld_state (ld_state)
);

// File: tb/pflag_fifo_test.sv
`timescale 1ns/1ps
module pflag_fifo_test;

    localparam int DEPTH = 64;

    logic       wclk = 0, rclk = 0, rst_n = 0;
    logic       wen_a = 0, wen_ld = 0, ren_a = 0, ren_b = 0;
    logic [8:0] wdata = '0;
    logic [8:0] rdata;
    logic       full, empty, almost_full_n, almost_empty_n;

    int tests = 0, fails = 0;
    bit done = 0;

    always #10 wclk = ~wclk;   // 50 MHz
    always #18 rclk = ~rclk;

    pflag_fifo #(.DEPTH(DEPTH)) uut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
        .wen_a(wen_a), .wen_ld(wen_ld), .wdata(wdata),
        .ren_a(ren_a), .ren_b(ren_b), .rdata(rdata),
        .full(full), .empty(empty),
        .almost_full_n(almost_full_n), .almost_empty_n(almost_empty_n)
    );

    typedef struct packed {
        logic       ld;
        logic [8:0] ae_lo, ae_hi, af_lo, af_hi;
        logic [6:0] cnt;
        logic       af_n, ae_n, fl, em;
    } vec_t;

    // Offsets for DEPTH 64 use bits [5:0] of the low half only (R5)
    localparam vec_t VEC [0:10] = '{
        '{1'b0, 9'd0,   9'd0,   9'd0,   9'd0,   7'd0,  1'b1, 1'b0, 1'b0, 1'b1},
        '{1'b0, 9'd0,   9'd0,   9'd0,   9'd0,   7'd8,  1'b1, 1'b0, 1'b0, 1'b0},
        '{1'b0, 9'd0,   9'd0,   9'd0,   9'd0,   7'd9,  1'b1, 1'b1, 1'b0, 1'b0},
        '{1'b0, 9'd0,   9'd0,   9'd0,   9'd0,   7'd55, 1'b1, 1'b1, 1'b0, 1'b0},
        '{1'b0, 9'd0,   9'd0,   9'd0,   9'd0,   7'd56, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b0, 9'd0,   9'd0,   9'd0,   9'd0,   7'd64, 1'b0, 1'b1, 1'b1, 1'b0},
        '{1'b1, 9'd0,   9'h1FF, 9'd0,   9'h1FF, 7'd63, 1'b1, 1'b1, 1'b0, 1'b0},
        '{1'b1, 9'd0,   9'h1FF, 9'd0,   9'h1FF, 7'd64, 1'b0, 1'b1, 1'b1, 1'b0},
        '{1'b1, 9'd3,   9'd0,   9'd20,  9'd0,   7'd3,  1'b1, 1'b0, 1'b0, 1'b0},
        '{1'b1, 9'd3,   9'd0,   9'd20,  9'd0,   7'd44, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 9'h1C3, 9'h0AA, 9'h0D4, 9'h0AA, 7'd43, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge wclk);
        wen_a = 0; wen_ld = 0; ren_a = 0; ren_b = 0;
        rst_n = 0;
        repeat (2) @(negedge rclk);
        @(negedge wclk) rst_n = 1;
        repeat (3) @(negedge rclk);
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
    endtask

    task automatic wr(input logic [8:0] d);
        @(negedge wclk) begin wen_a = 1; wen_ld = 0; wdata = d; end
        @(negedge wclk) wen_a = 0;
    endtask

    task automatic load(input logic [8:0] d);
        @(negedge wclk) begin wen_a = 1; wen_ld = 1; wdata = d; end
        @(negedge wclk) begin wen_a = 0; wen_ld = 0; end
    endtask

    task automatic rd(output logic [8:0] d);
        @(negedge rclk) begin ren_a = 1; ren_b = 1; end
        @(negedge rclk) begin ren_a = 0; ren_b = 0; end
        d = rdata;
    endtask

    initial begin
        #5ms;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [8:0] d;
        int bad;

        // R1: reset state, reached after storing data first
        do_reset();
        for (int i = 0; i < 5; i++) wr(9'(i));
        settle();
        do_reset();
        check("R1 empty", empty, 1);
        check("R1 full", full, 0);
        check("R1 almost_full_n", almost_full_n, 1);
        check("R1 almost_empty_n", almost_empty_n, 0);
        check("R1 rdata", rdata, 0);

        // Vector table: R5 R6 R9 R10 R2
        for (int v = 0; v < 11; v++) begin
            do_reset();
            if (VEC[v].ld) begin
                load(VEC[v].ae_lo); load(VEC[v].ae_hi);
                load(VEC[v].af_lo); load(VEC[v].af_hi);
            end
            for (int i = 0; i < int'(VEC[v].cnt); i++) wr(9'((i * 7 + v) & 9'h1FF));
            settle();
            check($sformatf("R6 vec%0d almost_full_n", v), almost_full_n, VEC[v].af_n);
            check($sformatf("R9 vec%0d almost_empty_n", v), almost_empty_n, VEC[v].ae_n);
            check($sformatf("R10 vec%0d full", v), full, VEC[v].fl);
            check($sformatf("R10 vec%0d empty", v), empty, VEC[v].em);
            bad = 0;
            for (int i = 0; i < int'(VEC[v].cnt); i++) begin
                rd(d);
                if (d !== 9'((i * 7 + v) & 9'h1FF)) bad++;
            end
            check($sformatf("R2 vec%0d order mismatches", v), bad, 0);
            settle();
            check($sformatf("R10 vec%0d empty after drain", v), empty, 1);
        end

        // R4: fifth load wraps to the nearly-empty low slot; loads do not store
        do_reset();
        load(9'd2); load(9'd0); load(9'd10); load(9'd0); load(9'd5);
        settle();
        check("R4 loads leave fifo empty", empty, 1);
        for (int i = 0; i < 5; i++) wr(9'(i));
        settle();
        check("R4 wrap ae offset 5 at count 5", almost_empty_n, 0);
        wr(9'd5);
        settle();
        check("R4 wrap ae offset 5 at count 6", almost_empty_n, 1);

        // R1: reset mid-sequence returns the sequencer to the first slot
        do_reset();
        load(9'd30); load(9'd0);
        do_reset();
        load(9'd1); load(9'd0); load(9'd8); load(9'd0);
        wr(9'd0);
        settle();
        check("R1 sequencer restart ae at count 1", almost_empty_n, 0);
        wr(9'd1);
        settle();
        check("R1 sequencer restart ae at count 2", almost_empty_n, 1);

        // R7: streaming writes, default offset 8
        do_reset();
        for (int k = 0; k <= 57; k++) begin
            @(negedge wclk);
            if (k == 56) check("R7 flag high after word 56", almost_full_n, 1);
            if (k == 57) check("R7 flag low after word 57", almost_full_n, 0);
            if (k < 57) begin wen_a = 1; wdata = 9'(k); end
            else wen_a = 0;
        end
        settle();

        // R8: release waits for the synchronizer
        rd(d);
        check("R2 stream first word", d, 0);
        rd(d);
        check("R2 stream second word", d, 1);
        check("R8 no release at read edge", almost_full_n, 0);
        settle();
        check("R8 release after crossing", almost_full_n, 1);

        // R3: overfill and over-read
        do_reset();
        for (int i = 0; i < 66; i++) wr(9'(i + 100));
        settle();
        check("R3 full after overfill", full, 1);
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            rd(d);
            if (d !== 9'(i + 100)) bad++;
        end
        check("R3 order after overfill", bad, 0);
        settle();
        check("R3 empty after drain", empty, 1);
        rd(d);
        check("R3 read on empty holds rdata", d, 9'd163);
        wr(9'h055);
        settle();
        rd(d);
        check("R3 pointers intact after over-read", d, 9'h055);
        settle();
        check("R3 empty again", empty, 1);

        // R11: single read enable and load select alone
        do_reset();
        @(negedge wclk) begin wen_a = 0; wen_ld = 1; wdata = 9'h1AB; end
        @(negedge wclk) wen_ld = 0;
        settle();
        check("R11 load select alone stores nothing", empty, 1);
        wr(9'h0F0);
        settle();
        @(negedge rclk) begin ren_a = 1; ren_b = 0; end
        @(negedge rclk) begin ren_a = 0; ren_b = 1; end
        @(negedge rclk) ren_b = 0;
        settle();
        check("R11 single enable rdata", rdata, 0);
        check("R11 single enable not empty", empty, 0);
        rd(d);
        check("R11 both enables read", d, 9'h0F0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule